// File: doc/BRIEF.md
# Address Table Command Engine

This block holds a small table of learned MAC addresses for an Ethernet switch and changes or inspects it through a command interface. Software fills a MAC register triple, a data register and a database number, then writes the operation register with its busy bit set and an opcode. The engine walks its internal entry array, one entry per clock. It loads or purges a single entry, returns the next valid entry in MAC order, or flushes or moves entries. When the command finishes it drops busy. Results come back in the same data and MAC registers.

Flush and move share one set of four opcodes. The state field of the data register picks the action: 0 flushes and 15 moves. The opcode picks the scope: every database or only the selected one, and every entry or only the dynamic ones. The engine also latches learning violations reported by the forwarding path, and a load that finds no free slot. Software reads these back, and clears them, with a get-and-clear command.

Top module: `addr_table_engine`

## Requirements
- R1: A register write to address 0 with bit 15 set and a non-zero opcode in bits [14:12] starts a command only when busy is clear. Busy reads 1 at once and returns to 0 within 18 clock cycles. Bits [14:12] read back the last accepted opcode. An address-0 write with bit 15 clear, or with opcode 0, starts nothing and updates only the database low nibble. Opcodes: 1 flush/move all entries in every database, 2 flush/move dynamic entries in every database, 3 load/purge, 4 get-next, 5 flush/move all entries in the selected database, 6 flush/move dynamic entries in the selected database, 7 get-and-clear violations.
- R2: While busy is set, register writes to every address are ignored, including a second command start.
- R3: The data register (address 2) holds the entry state in [3:0], the port vector in [11:4] and the trunk flag in [15]. When the state is 0 the register reads back as 0. The MAC sits in addresses 3, 4 and 5, two bytes each, with byte 0 (the most significant) in bits [15:8] of address 3.
- R4: The 8-bit database number is the concatenation of control register (address 1) bits [15:12], which form the high nibble, and operation register bits [3:0], which form the low nibble.
- R5: Load (3) with a non-zero state stores the MAC, data and database. If an entry with the same MAC and database already exists, it is overwritten in place.
- R6: Load with state 0 removes the entry whose MAC and database match, and leaves every other entry alone.
- R7: A load that matches nothing while all entries are in use changes no entry and latches the full flag.
- R8: Get-next (4) returns the valid entry of the selected database that has the smallest MAC greater than the MAC register. An all-ones MAC register starts from the lowest MAC. When no entry qualifies, the MAC registers read all-ones and the data register reads 0.
- R9: With data state 0, opcodes 1, 2, 5 and 6 remove the entries in their scope. State 15 marks a static entry, which the dynamic-only opcodes 2 and 6 skip.
- R10: With data state 15, the same opcodes move entries instead. The from-port is port-vector bits [3:0] (data [7:4]) and the to-port is bits [7:4] (data [11:8]). An entry that has the from-port loses it and gains the to-port. A to-port of 15 only removes the port. An entry left with no ports is removed. Any other data state changes nothing.
- R11: The age time is control bits [11:4] and resets to 20. A write with 0 in that field keeps the old age time, while the other control bits still update.
- R12: Violation inputs (age-out, member, miss) and the full condition are latched. Get-and-clear (7) places the flags in operation bits [7:4] (age-out 7, member 6, miss 5, full 4). It also returns the first event's MAC, database (through R4's fields), source port in the state field and port vector, then clears the latch. A second get-and-clear reports flags 0.
- R13: After reset, every register reads 0 except the age time, and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Register read data, combinational |
| vioValid | input | 1 | Learning violation event this cycle |
| vioMember | input | 1 | Event is a membership violation |
| vioMiss | input | 1 | Event is a lookup miss |
| vioAgeOut | input | 1 | Event is an age-out |
| vioSpid | input | 4 | Source port of the event |
| vioMac | input | 48 | MAC of the event |
| vioDb | input | 8 | Database of the event |
| vioPv | input | 8 | Port vector of the event |

## Verification
Loads place entries in two databases, mixing static and dynamic states, and include one overwrite of an existing MAC. Get-next walks from an all-ones start then show that ordering follows the MAC and not the slot, and that the walk stays inside one database. Each flush scope runs on a table that has entries in and out of its scope, so a wrong static or database filter shows up as a surviving or missing entry. Move runs with a to-port, then with the remove code, then with a neutral state. Filling the table with fresh MACs separates the full-violation path from an overwrite.

// File: rtl/addr_table_pkg.sv
`timescale 1ns/1ps
package addr_table_pkg;
  typedef enum logic [2:0] {
    CMD_NONE        = 3'd0,
    CMD_FLUSH_ALL   = 3'd1,
    CMD_FLUSH_DYN   = 3'd2,
    CMD_LOAD        = 3'd3,
    CMD_NEXT        = 3'd4,
    CMD_FLUSH_ALLDB = 3'd5,
    CMD_FLUSH_DYNDB = 3'd6,
    CMD_VIO         = 3'd7
  } cmd_e;

  localparam logic [2:0] ADDR_OP   = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_DATA = 3'd2;
  localparam logic [2:0] ADDR_MAC0 = 3'd3;
  localparam logic [2:0] ADDR_MAC1 = 3'd4;
  localparam logic [2:0] ADDR_MAC2 = 3'd5;

  localparam int PV_W = 8;
  localparam logic [3:0] STATE_STATIC = 4'hF;

  typedef struct packed {
    logic [3:0]      state;
    logic            trunk;
    logic [PV_W-1:0] pv;
    logic [7:0]      db;
    logic [47:0]     mac;
  } entry_t;

  typedef struct packed {
    logic scan;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/atc_control.sv
`timescale 1ns/1ps
module atc_control
  import addr_table_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  cmd_e             startOp,
  output strobe_t          stb,
  output logic [IDX_W-1:0] scanIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} state_e;
  state_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startCmd) begin
          scanIdx <= '0;
          state   <= (startOp == CMD_VIO) ? ST_FIN : ST_SCAN;
        end
        ST_SCAN: begin
          if (scanIdx == LAST_IDX) state <= ST_FIN;
          else scanIdx <= scanIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.scan   = (state == ST_SCAN);
    stb.finish = (state == ST_FIN);
  end

  // R1
  start_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (stb.scan || stb.finish));
endmodule

// File: rtl/atc_datapath.sv
`timescale 1ns/1ps
module atc_datapath
  import addr_table_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W = 4,
  parameter logic [7:0] AGE_RESET = 8'd20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [15:0]      regWrData,
  input  logic [2:0]       rdAddr,
  output logic [15:0]      rdData,
  input  logic             vioValid,
  input  logic             vioMember,
  input  logic             vioMiss,
  input  logic             vioAgeOut,
  input  logic [3:0]       vioSpid,
  input  logic [47:0]      vioMac,
  input  logic [7:0]       vioDb,
  input  logic [PV_W-1:0]  vioPv,
  input  strobe_t          stb,
  input  logic [IDX_W-1:0] scanIdx,
  output logic             startCmd,
  output cmd_e             startOp
);
  localparam logic [47:0] MAC_ONES = '1;

  entry_t tbl [NUM_ENTRIES];

  logic            opBusy;
  cmd_e            opCmd;
  logic [3:0]      dbLo, dbHi;
  logic [7:0]      ageTime;
  logic [3:0]      rptFlags;
  logic [3:0]      dState;
  logic            dTrunk;
  logic [PV_W-1:0] dPv;
  logic [47:0]     macReg;

  logic [3:0]      pendFlags;
  logic [47:0]     capMac;
  logic [7:0]      capDb;
  logic [3:0]      capSpid;
  logic [PV_W-1:0] capPv;

  logic             matchFound, freeFound, bestFound;
  logic [IDX_W-1:0] matchIdx, freeIdx, bestIdx;
  logic [47:0]      bestMac;

  logic       wrOk;
  logic [7:0] dbSel;
  entry_t     cur, moved, newEnt;
  logic       live, dbHit, nextHit, fmHit;
  logic       clrVio, fullEvt;
  logic [3:0] newFlags, pendBase;

  assign wrOk     = regWrEn && !opBusy;
  assign startOp  = cmd_e'(regWrData[14:12]);
  assign startCmd = wrOk && (regAddr == ADDR_OP) && regWrData[15] && (regWrData[14:12] != 3'd0);
  assign dbSel    = {dbHi, dbLo};
  assign newEnt   = '{state: dState, trunk: dTrunk, pv: dPv, db: dbSel, mac: macReg};

  // per-entry scan evaluation
  always_comb begin
    logic [3:0]      fromP, toP;
    logic [PV_W-1:0] npv;
    logic            scopeOk, kindOk;
    cur     = tbl[scanIdx];
    live    = (cur.state != 4'd0);
    dbHit   = (cur.db == dbSel);
    nextHit = live && dbHit && ((macReg == MAC_ONES) || (cur.mac > macReg)) &&
              (!bestFound || (cur.mac < bestMac));
    scopeOk = !((opCmd == CMD_FLUSH_ALLDB) || (opCmd == CMD_FLUSH_DYNDB)) || dbHit;
    kindOk  = !((opCmd == CMD_FLUSH_DYN) || (opCmd == CMD_FLUSH_DYNDB)) || (cur.state != STATE_STATIC);
    fmHit   = live && scopeOk && kindOk;
    fromP   = dPv[3:0];
    toP     = dPv[7:4];
    npv     = cur.pv;
    moved   = cur;
    if (dState == 4'd0) begin
      moved = '0;
    end else if (dState == STATE_STATIC) begin
      if (fromP < 4'd8 && cur.pv[fromP[2:0]]) begin
        npv = cur.pv & ~(PV_W'(1) << fromP[2:0]);
        if (toP < 4'd8) npv = npv | (PV_W'(1) << toP[2:0]);
        if (npv == '0) moved = '0;
        else moved.pv = npv;
      end
    end
  end

  // violation latch inputs
  always_comb begin
    clrVio   = stb.finish && (opCmd == CMD_VIO);
    fullEvt  = stb.finish && (opCmd == CMD_LOAD) && (dState != 4'd0) && !matchFound && !freeFound;
    newFlags = {vioValid && vioAgeOut, vioValid && vioMember, vioValid && vioMiss, fullEvt};
    pendBase = clrVio ? 4'd0 : pendFlags;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
      opBusy <= 1'b0; opCmd <= CMD_NONE; dbLo <= '0; dbHi <= '0;
      ageTime <= AGE_RESET; rptFlags <= '0;
      dState <= '0; dTrunk <= 1'b0; dPv <= '0; macReg <= '0;
      pendFlags <= '0; capMac <= '0; capDb <= '0; capSpid <= '0; capPv <= '0;
      matchFound <= 1'b0; freeFound <= 1'b0; bestFound <= 1'b0;
      matchIdx <= '0; freeIdx <= '0; bestIdx <= '0; bestMac <= '0;
    end else begin
      if (wrOk) begin
        case (regAddr)
          ADDR_OP: begin
            dbLo <= regWrData[3:0];
            if (startCmd) begin
              opBusy <= 1'b1;
              opCmd  <= startOp;
            end
          end
          ADDR_CTRL: begin
            dbHi <= regWrData[15:12];
            if (regWrData[11:4] != 8'd0) ageTime <= regWrData[11:4];
          end
          ADDR_DATA: begin
            dState <= regWrData[3:0];
            dPv    <= regWrData[11:4];
            dTrunk <= regWrData[15];
          end
          ADDR_MAC0: macReg[47:32] <= regWrData;
          ADDR_MAC1: macReg[31:16] <= regWrData;
          ADDR_MAC2: macReg[15:0]  <= regWrData;
          default: ;
        endcase
      end

      if (startCmd) begin
        matchFound <= 1'b0;
        freeFound  <= 1'b0;
        bestFound  <= 1'b0;
      end

      if (stb.scan) begin
        case (opCmd)
          CMD_LOAD: begin
            if (live && dbHit && (cur.mac == macReg)) begin
              matchFound <= 1'b1;
              matchIdx   <= scanIdx;
            end
            if (!live && !freeFound) begin
              freeFound <= 1'b1;
              freeIdx   <= scanIdx;
            end
          end
          CMD_NEXT: if (nextHit) begin
            bestFound <= 1'b1;
            bestIdx   <= scanIdx;
            bestMac   <= cur.mac;
          end
          CMD_FLUSH_ALL, CMD_FLUSH_DYN, CMD_FLUSH_ALLDB, CMD_FLUSH_DYNDB:
            if (fmHit) tbl[scanIdx] <= moved;
          default: ;
        endcase
      end

      if (stb.finish) begin
        opBusy <= 1'b0;
        case (opCmd)
          CMD_LOAD: begin
            if (dState != 4'd0) begin
              if (matchFound) tbl[matchIdx] <= newEnt;
              else if (freeFound) tbl[freeIdx] <= newEnt;
            end else if (matchFound) begin
              tbl[matchIdx] <= '0;
            end
          end
          CMD_NEXT: begin
            if (bestFound) begin
              dState <= tbl[bestIdx].state;
              dTrunk <= tbl[bestIdx].trunk;
              dPv    <= tbl[bestIdx].pv;
              macReg <= bestMac;
            end else begin
              dState <= '0; dTrunk <= 1'b0; dPv <= '0;
              macReg <= MAC_ONES;
            end
          end
          CMD_VIO: begin
            rptFlags <= pendFlags;
            macReg   <= capMac;
            dbLo     <= capDb[3:0];
            dbHi     <= capDb[7:4];
            dState   <= capSpid;
            dPv      <= capPv;
            dTrunk   <= 1'b0;
          end
          default: ;
        endcase
      end

      pendFlags <= pendBase | newFlags;
      if ((newFlags != 4'd0) && (pendBase == 4'd0)) begin
        if (vioValid && (newFlags[3:1] != 3'd0)) begin
          capMac <= vioMac; capDb <= vioDb; capSpid <= vioSpid; capPv <= vioPv;
        end else begin
          capMac <= macReg; capDb <= dbSel; capSpid <= 4'd0; capPv <= dPv;
        end
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_OP:   rdData = {opBusy, opCmd, 4'd0, rptFlags, dbLo};
      ADDR_CTRL: rdData = {dbHi, ageTime, 4'd0};
      ADDR_DATA: rdData = (dState == 4'd0) ? 16'd0 : {dTrunk, 3'd0, dPv, dState};
      ADDR_MAC0: rdData = macReg[47:32];
      ADDR_MAC1: rdData = macReg[31:16];
      ADDR_MAC2: rdData = macReg[15:0];
      default:   rdData = 16'd0;
    endcase
  end

  // R1
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opBusy) |-> $past(regWrEn && (regAddr == ADDR_OP) && regWrData[15]));
  // R1
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !opBusy);
  // R1
  finish_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> opBusy);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opBusy && !stb.finish) |=> $stable({dState, dPv, dTrunk, macReg, dbHi}));
  // R11
  age_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ageTime != 8'd0);
endmodule

// File: rtl/addr_table_engine.sv
`timescale 1ns/1ps
module addr_table_engine
  import addr_table_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter logic [7:0] AGE_RESET = 8'd20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWrData,
  input  logic [2:0]  rdAddr,
  output logic [15:0] rdData,
  input  logic        vioValid,
  input  logic        vioMember,
  input  logic        vioMiss,
  input  logic        vioAgeOut,
  input  logic [3:0]  vioSpid,
  input  logic [47:0] vioMac,
  input  logic [7:0]  vioDb,
  input  logic [7:0]  vioPv
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  strobe_t          stb;
  logic [IDX_W-1:0] scanIdx;
  logic             startCmd;
  cmd_e             startOp;

  atc_control #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .startOp(startOp),
    .stb(stb), .scanIdx(scanIdx)
  );

  atc_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .AGE_RESET(AGE_RESET)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .rdAddr(rdAddr), .rdData(rdData), .vioValid(vioValid), .vioMember(vioMember),
    .vioMiss(vioMiss), .vioAgeOut(vioAgeOut), .vioSpid(vioSpid), .vioMac(vioMac),
    .vioDb(vioDb), .vioPv(vioPv), .stb(stb), .scanIdx(scanIdx),
    .startCmd(startCmd), .startOp(startOp)
  );
endmodule

// File: tb/addr_table_engine_tb.sv
`timescale 1ns/1ps
module addr_table_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        vioValid = 1'b0, vioMember = 1'b0, vioMiss = 1'b0, vioAgeOut = 1'b0;
  logic [3:0]  vioSpid = '0;
  logic [47:0] vioMac = '0;
  logic [7:0]  vioDb = '0;
  logic [7:0]  vioPv = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_table_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .rdAddr(rdAddr), .rdData(rdData), .vioValid(vioValid), .vioMember(vioMember),
    .vioMiss(vioMiss), .vioAgeOut(vioAgeOut), .vioSpid(vioSpid), .vioMac(vioMac),
    .vioDb(vioDb), .vioPv(vioPv)
  );

  // behavioural reference: table contents and expected register values
  logic [47:0] mMac [16];
  logic [7:0]  mDb  [16];
  logic [3:0]  mSt  [16];
  logic        mTr  [16];
  logic [7:0]  mPv  [16];
  logic [2:0]  eCmd = 0;
  logic [3:0]  eDbLo = 0, eDbHi = 0, eFlags = 0, eSt = 0;
  logic [7:0]  eAge = 8'd20, ePv = 0;
  logic        eTr = 0;
  logic [47:0] eMac = 0;
  logic [3:0]  pFlags = 0, pSpid = 0;
  logic [47:0] pMac = 0;
  logic [7:0]  pDb = 0, pPv = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic checkRegs(input string tag);
    logic [15:0] v;
    readReg(3'd0, v); check({tag, " op"},   v, {1'b0, eCmd, 4'd0, eFlags, eDbLo});
    readReg(3'd1, v); check({tag, " ctrl"}, v, {eDbHi, eAge, 4'd0});
    readReg(3'd2, v); check({tag, " data"}, v, (eSt == 0) ? 16'd0 : {eTr, 3'd0, ePv, eSt});
    readReg(3'd3, v); check({tag, " mac0"}, v, eMac[47:32]);
    readReg(3'd4, v); check({tag, " mac1"}, v, eMac[31:16]);
    readReg(3'd5, v); check({tag, " mac2"}, v, eMac[15:0]);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setMac(input logic [47:0] m);
    wrReg(3'd3, m[47:32]); wrReg(3'd4, m[31:16]); wrReg(3'd5, m[15:0]);
    eMac = m;
  endtask

  task automatic setData(input logic [3:0] st, input logic tr, input logic [7:0] pv);
    wrReg(3'd2, {tr, 3'd0, pv, st});
    eSt = st; eTr = tr; ePv = pv;
  endtask

  task automatic setDbHi(input logic [3:0] h);
    wrReg(3'd1, {h, eAge, 4'd0});
    eDbHi = h;
  endtask

  function automatic void raise(input logic [3:0] f, input logic [47:0] m, input logic [7:0] d,
                                input logic [3:0] s, input logic [7:0] p);
    if (pFlags == 0) begin pMac = m; pDb = d; pSpid = s; pPv = p; end
    pFlags = pFlags | f;
  endfunction

  function automatic void modelExec(input logic [2:0] op);
    logic [7:0] sel;
    int match, free, best;
    sel = {eDbHi, eDbLo};
    match = -1; free = -1; best = -1;
    case (op)
      3'd3: begin
        for (int i = 0; i < 16; i++) begin
          if (mSt[i] != 0 && mDb[i] == sel && mMac[i] == eMac) match = i;
          if (mSt[i] == 0 && free < 0) free = i;
        end
        if (eSt != 0) begin
          if (match < 0) match = free;
          if (match >= 0) begin
            mSt[match] = eSt; mTr[match] = eTr; mPv[match] = ePv; mDb[match] = sel; mMac[match] = eMac;
          end else raise(4'b0001, eMac, sel, 4'd0, ePv);
        end else if (match >= 0) mSt[match] = 0;
      end
      3'd4: begin
        for (int i = 0; i < 16; i++)
          if (mSt[i] != 0 && mDb[i] == sel && (eMac == '1 || mMac[i] > eMac))
            if (best < 0 || mMac[i] < mMac[best]) best = i;
        if (best >= 0) begin
          eSt = mSt[best]; eTr = mTr[best]; ePv = mPv[best]; eMac = mMac[best];
        end else begin
          eSt = 0; eTr = 0; ePv = 0; eMac = '1;
        end
      end
      3'd7: begin
        eFlags = pFlags; eMac = pMac; eDbLo = pDb[3:0]; eDbHi = pDb[7:4];
        eSt = pSpid; ePv = pPv; eTr = 0; pFlags = 0;
      end
      default: begin
        for (int i = 0; i < 16; i++) begin
          logic inScope;
          logic [3:0] f, t;
          logic [7:0] npv;
          inScope = (mSt[i] != 0) && (op == 3'd1 || op == 3'd2 || mDb[i] == sel) &&
                    (op == 3'd1 || op == 3'd5 || mSt[i] != 4'hF);
          f = ePv[3:0]; t = ePv[7:4];
          if (inScope) begin
            if (eSt == 0) mSt[i] = 0;
            else if (eSt == 4'hF && f < 8 && mPv[i][f[2:0]]) begin
              npv = mPv[i] & ~(8'd1 << f[2:0]);
              if (t < 8) npv = npv | (8'd1 << t[2:0]);
              if (npv == 0) mSt[i] = 0;
              else mPv[i] = npv;
            end
          end
        end
      end
    endcase
  endfunction

  task automatic startCmd(input logic [2:0] op, input logic [3:0] lo);
    logic [15:0] v;
    wrReg(3'd0, {1'b1, op, 8'd0, lo});
    eCmd = op; eDbLo = lo;
    readReg(3'd0, v);
    check("R1 busy set after start", {15'd0, v[15]}, 16'd1);
  endtask

  task automatic finishCmd(input logic [2:0] op, input string tag);
    logic [15:0] v;
    int n;
    n = 0;
    readReg(3'd0, v);
    while (v[15] && n < 40) begin
      @(negedge clk); n++;
      readReg(3'd0, v);
    end
    check("R1 busy clears in time", 16'(n <= 17), 16'd1);
    modelExec(op);
    checkRegs(tag);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [3:0] lo, input string tag);
    startCmd(op, lo);
    finishCmd(op, tag);
  endtask

  task automatic load(input logic [7:0] db, input logic [47:0] m, input logic [3:0] st,
                      input logic tr, input logic [7:0] pv, input string tag);
    setDbHi(db[7:4]); setMac(m); setData(st, tr, pv);
    cmd(3'd3, db[3:0], tag);
  endtask

  task automatic walk(input logic [7:0] db, input string tag);
    setDbHi(db[7:4]); setMac('1);
    for (int k = 0; k < 18; k++) begin
      cmd(3'd4, db[3:0], tag);
      if (eSt == 0) break;
    end
  endtask

  task automatic pulseVio(input logic ag, input logic mb, input logic ms, input logic [3:0] s,
                          input logic [47:0] m, input logic [7:0] d, input logic [7:0] p);
    @(negedge clk);
    vioValid = 1; vioAgeOut = ag; vioMember = mb; vioMiss = ms; vioSpid = s; vioMac = m; vioDb = d; vioPv = p;
    @(negedge clk);
    vioValid = 0; vioAgeOut = 0; vioMember = 0; vioMiss = 0;
    raise({ag, mb, ms, 1'b0}, m, d, s, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin mSt[i] = 0; mMac[i] = 0; mDb[i] = 0; mTr[i] = 0; mPv[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R13 reset");
    walk(8'h11, "R13 empty table walk R8");

    // R3 R4 R5: loads across two databases, static and dynamic
    load(8'h11, 48'h0050_C200_1234, 4'd7, 1'b0, 8'h02, "R5 load a");
    load(8'h11, 48'h0010_0000_0001, 4'hF, 1'b1, 8'h06, "R5 load static b");
    load(8'h11, 48'h00A0_0000_0777, 4'd3, 1'b0, 8'h03, "R5 load c");
    load(8'h22, 48'h0010_0000_0001, 4'd5, 1'b0, 8'h01, "R4 other db same mac");
    load(8'h22, 48'h0020_0000_0002, 4'hF, 1'b0, 8'h12, "R4 other db static");
    load(8'h11, 48'h0050_C200_1234, 4'd9, 1'b1, 8'h0A, "R5 overwrite a");
    walk(8'h11, "R8 walk db11");
    walk(8'h22, "R8 walk db22 R3");

    // R3: state 0 hides port vector and trunk
    setData(4'd0, 1'b1, 8'hFF);
    checkRegs("R3 state zero reads zero");

    // R6: purge one entry
    load(8'h11, 48'h00A0_0000_0777, 4'd0, 1'b0, 8'h00, "R6 purge c");
    walk(8'h11, "R6 walk after purge");

    // R2: writes during busy ignored
    setData(4'd0, 1'b0, 8'h00);
    setDbHi(4'hE);
    startCmd(3'd6, 4'hE);
    wrReg(3'd2, 16'h8F5A);
    wrReg(3'd3, 16'hBEEF);
    wrReg(3'd1, 16'h3330);
    wrReg(3'd0, {1'b1, 3'd4, 8'd0, 4'h1});
    finishCmd(3'd6, "R2 writes while busy ignored");

    // R10: move port 1 to port 3 in db 0x11
    setDbHi(4'h1);
    setData(4'hF, 1'b0, 8'h31);
    cmd(3'd5, 4'h1, "R10 move cmd");
    walk(8'h11, "R10 walk after move");
    walk(8'h22, "R10 other db untouched");
    setData(4'hF, 1'b0, 8'hF3);
    cmd(3'd1, 4'h1, "R10 remove port 3");
    walk(8'h11, "R10 walk after remove");
    setData(4'd5, 1'b0, 8'h12);
    cmd(3'd1, 4'h1, "R10 neutral state");
    walk(8'h22, "R10 walk after neutral");

    // R9: flush variants
    load(8'h22, 48'h0030_0000_0003, 4'd4, 1'b0, 8'h04, "R9 add dyn db22");
    load(8'h33, 48'h0040_0000_0004, 4'd4, 1'b0, 8'h04, "R9 add dyn db33");
    load(8'h33, 48'h0041_0000_0004, 4'hF, 1'b0, 8'h04, "R9 add static db33");
    setData(4'd0, 1'b0, 8'h00);
    setDbHi(4'h2);
    cmd(3'd6, 4'h2, "R9 flush dyn db22");
    walk(8'h22, "R9 walk db22 after dyn flush");
    walk(8'h33, "R9 db33 untouched");
    setData(4'd0, 1'b0, 8'h00);
    cmd(3'd2, 4'h0, "R9 flush dyn all db");
    walk(8'h33, "R9 walk db33 statics stay");
    walk(8'h11, "R9 walk db11 statics stay");
    setData(4'd0, 1'b0, 8'h00);
    setDbHi(4'h3);
    cmd(3'd5, 4'h3, "R9 flush all db33");
    walk(8'h33, "R9 walk db33 empty");
    walk(8'h22, "R9 walk db22 static stays");
    setData(4'd0, 1'b0, 8'h00);
    cmd(3'd1, 4'h0, "R9 flush all");
    walk(8'h22, "R9 walk db22 empty");
    walk(8'h11, "R9 walk db11 empty");

    // R7: fill table, one more load is refused
    for (int i = 0; i < 17; i++)
      load(8'h40, 48'h0200_0000_0000 + 48'(i), 4'd2, 1'b0, 8'h01, "R7 fill");
    walk(8'h40, "R7 walk full table");
    cmd(3'd7, 4'h0, "R7 R12 full flag");
    cmd(3'd7, 4'h0, "R12 second clear empty");

    // R12: learning violations, first event captured
    pulseVio(1'b0, 1'b1, 1'b0, 4'd6, 48'h0A0B_0C0D_0E0F, 8'hA5, 8'h40);
    pulseVio(1'b1, 1'b0, 1'b1, 4'd2, 48'h1111_2222_3333, 8'h07, 8'h04);
    cmd(3'd7, 4'h0, "R12 R4 violation report");
    cmd(3'd7, 4'h0, "R12 cleared");

    // R11: age time
    wrReg(3'd1, {4'h6, 8'h00, 4'h0}); eDbHi = 4'h6;
    checkRegs("R11 zero age ignored");
    wrReg(3'd1, {4'h6, 8'hFF, 4'h0}); eAge = 8'hFF;
    checkRegs("R11 age max");

    // R1: writes to op that do not start
    wrReg(3'd0, {1'b0, 3'd4, 8'd0, 4'h3}); eDbLo = 4'h3;
    checkRegs("R1 no busy bit");
    wrReg(3'd0, {1'b1, 3'd0, 8'd0, 4'h9}); eDbLo = 4'h9;
    checkRegs("R1 opcode zero");
    readReg(3'd0, v);
    check("R1 idle after null op", {15'd0, v[15]}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule